// File: doc/BRIEF.md
# Repeat and Loop Execution Sequencer

This block sits beside the head of an instruction queue. Each cycle it looks at the head instruction and decides its fate. The instruction may execute and stay at the head for another repetition. It may finish and be written back to the tail of the queue to run again (a reloop). Or it may finish and leave the queue (retire). The block owns two counters that drive these decisions. The repeat counter holds a finite value or a sticky "infinite" marker. The loop counter counts relooping passes and never goes below zero.

The surrounding dock supplies a few facts about the head instruction: its class bits, the result of its predicate, its decrement-loop bit and any counter-load command it carries. It also supplies whether the queue tail has room and whether the downstream stage can accept work. In return the block raises one-cycle strobes for execute, requeue and retire, and exposes both counters so that copy-out instructions can read them. The datapath work of the instructions and the queue storage belong to other blocks.

A step is the cycle in which the head is acted on. It needs a valid head and a ready downstream stage. It also needs tail space, but only when the step is going to reloop.

Top module: `rpt_loop_seq`

## Requirements
- R1: After reset the repeat counter reads 0 with the infinite marker clear, the loop counter reads 0, and no strobe is raised.
- R2: No strobe is raised in a cycle where the head is not valid or the downstream stage is not ready.
- R3: In a step, exec_o is high exactly when the predicate is true, and at most one of requeue_o and retire_o is high.
- R4: A step of a repeating-class instruction with a true predicate and a nonzero finite repeat count lowers the count by one. The instruction stays at the head (no requeue, no retire) while the lowered count is nonzero. A count of N>0 therefore gives N executions, and a count of 0 gives one.
- R5: A repeating-class instruction with a true predicate and the infinite marker set executes on every step, never finishes, and leaves the marker set.
- R6: Any other step leaves the repeat counter unchanged, unless it is a repeat-counter load with a true predicate.
- R7: A finishing step requeues only when three things hold: the instruction is in the relooping class, the repeat counter is zero, and the loop count is above zero. Otherwise it retires.
- R8: The loop-count test of R7 uses the value written by a loop-counter load in the same instruction. It does not see that instruction's own decrement.
- R9: When the decrement-loop bit is set, a finishing step lowers the loop counter by one, whatever the predicate. A decrement at zero leaves it at zero.
- R10: A false predicate suppresses exec_o and any counter load, and blocks repetition, but the step may still requeue.
- R11: With the tail full, a step that would requeue is held (no strobe, no counter change). A step that would retire or repeat still goes ahead.
- R12: A repeat-counter load writes one of three values: the 6-bit literal zero-extended, the low bits of data_i, or the infinite marker (ld_rc_inf_i, which clears the count to 0). A loop-counter load writes the 6-bit literal zero-extended, or the low bits of data_i. ld_from_data_i selects data_i for both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_valid_i | input | 1 | An instruction is present at the queue head |
| ds_ready_i | input | 1 | Downstream stage can accept an execution |
| tail_full_i | input | 1 | Queue tail has no room for a requeued entry |
| rep_class_i | input | 1 | Head instruction belongs to the repeating class |
| reloop_class_i | input | 1 | Head instruction belongs to the relooping class |
| pred_i | input | 1 | Predicate of the head instruction holds |
| dec_loop_i | input | 1 | Decrement-loop bit of the head instruction |
| ld_rc_i | input | 1 | Head instruction loads the repeat counter |
| ld_rc_inf_i | input | 1 | Repeat-counter load writes the infinite marker |
| ld_lc_i | input | 1 | Head instruction loads the loop counter |
| ld_from_data_i | input | 1 | Counter load takes data_i instead of the literal |
| lit_i | input | 6 | Literal count field |
| data_i | input | 8 | Data-latch value for counter loads |
| exec_o | output | 1 | Execute strobe |
| requeue_o | output | 1 | Head is finished and goes back to the tail |
| retire_o | output | 1 | Head is finished and leaves the queue |
| rc_o | output | 8 | Repeat counter value |
| rc_inf_o | output | 1 | Repeat counter holds the infinite marker |
| lc_o | output | 8 | Loop counter value |

## Verification
A wrong counter value shows first in the strobe pattern: too few or too many exec_o pulses before retire_o, or a requeue_o where a retire_o belongs. It also shows on rc_o and lc_o one edge after the step that wrote it. An infinite marker that is lost makes a repeating instruction retire after a short run instead of holding the head. A reloop test taken after the decrement instead of before turns the last requeue of a loop into a retire on the very step where the count is one. A tail-full gate applied to the wrong case shows as a stalled retire, or as a requeue_o while tail_full_i is high, in the same cycle.

// File: rtl/rls_pkg.sv
package rls_pkg;
  typedef enum logic [1:0] {
    SK_IDLE    = 2'd0,
    SK_AGAIN   = 2'd1,
    SK_REQUEUE = 2'd2,
    SK_RETIRE  = 2'd3
  } step_kind_e;
endpackage

// File: rtl/rls_decide.sv
module rls_decide
  import rls_pkg::*;
(
  input  logic       head_valid_i,
  input  logic       ds_ready_i,
  input  logic       tail_full_i,
  input  logic       rep_class_i,
  input  logic       reloop_class_i,
  input  logic       pred_i,
  input  logic       rc_zero_i,
  input  logic       rc_next_zero_i,
  input  logic       lc_eff_pos_i,
  output logic       step_o,
  output logic       repeating_o,
  output logic       finish_o,
  output step_kind_e kind_o
);
  logic want_reloop;
  logic rc_test_zero;

  always_comb begin
    // repetition needs the repeating class, a true predicate and a live count
    repeating_o  = rep_class_i && pred_i && !rc_zero_i;
    finish_o     = !(repeating_o && !rc_next_zero_i);
    // a repetition that finishes has just brought the count to zero
    rc_test_zero = repeating_o || rc_zero_i;
    want_reloop  = finish_o && reloop_class_i && lc_eff_pos_i && rc_test_zero;
    // tail space matters only for an entry that goes back to the tail
    step_o       = head_valid_i && ds_ready_i && !(want_reloop && tail_full_i);
    if (!step_o)        kind_o = SK_IDLE;
    else if (!finish_o) kind_o = SK_AGAIN;
    else if (want_reloop) kind_o = SK_REQUEUE;
    else                kind_o = SK_RETIRE;
  end
endmodule

// File: rtl/rls_rc_unit.sv
module rls_rc_unit #(
  parameter int RCW  = 8,
  parameter int LITW = 6,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rep_fire_i,
  input  logic            ld_fire_i,
  input  logic            ld_inf_i,
  input  logic            ld_data_i,
  input  logic [LITW-1:0] lit_i,
  input  logic [DW-1:0]   data_i,
  output logic [RCW-1:0]  rc_o,
  output logic            rc_inf_o,
  output logic            rc_zero_o,
  output logic            rc_next_zero_o
);
  logic [RCW-1:0] rc_q;
  logic           inf_q;

  function automatic logic [RCW-1:0] rc_less(input logic [RCW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q  <= '0;
      inf_q <= 1'b0;
    end else if (ld_fire_i) begin
      inf_q <= ld_inf_i;
      if (ld_inf_i)       rc_q <= '0;
      else if (ld_data_i) rc_q <= data_i[RCW-1:0];
      else                rc_q <= RCW'(lit_i);
    end else if (rep_fire_i && !inf_q) begin
      rc_q <= rc_less(rc_q);
    end
  end

  assign rc_o           = rc_q;
  assign rc_inf_o       = inf_q;
  assign rc_zero_o      = !inf_q && (rc_q == '0);
  assign rc_next_zero_o = !inf_q && (rc_less(rc_q) == '0);

  // R4: a finite repetition removes exactly one from the count
  a_r4_rc_dec: assert property (@(posedge clk) disable iff (!rst_n)
    rep_fire_i && !ld_fire_i && !inf_q |=> rc_q == RCW'($past(rc_q) - 1'b1));
  // R5: the infinite marker survives repetitions
  a_r5_inf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    inf_q && !ld_fire_i |=> inf_q);
  // R6: without a repetition or a load nothing moves
  a_r6_rc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_fire_i && !ld_fire_i |=> $stable(rc_q) && $stable(inf_q));
endmodule

// File: rtl/rls_lc_unit.sv
module rls_lc_unit #(
  parameter int LCW  = 8,
  parameter int LITW = 6,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_req_i,
  input  logic            ld_data_i,
  input  logic [LITW-1:0] lit_i,
  input  logic [DW-1:0]   data_i,
  input  logic            fin_fire_i,
  input  logic            dec_i,
  output logic [LCW-1:0]  lc_o,
  output logic            lc_eff_pos_o
);
  logic [LCW-1:0] lc_q;
  logic [LCW-1:0] lc_eff;

  function automatic logic [LCW-1:0] lc_less(input logic [LCW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  // value the reloop test sees: a same-instruction load counts, the decrement does not
  always_comb begin
    if (ld_req_i) lc_eff = ld_data_i ? data_i[LCW-1:0] : LCW'(lit_i);
    else          lc_eff = lc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lc_q <= '0;
    else if (fin_fire_i) lc_q <= dec_i ? lc_less(lc_eff) : lc_eff;
  end

  assign lc_o         = lc_q;
  assign lc_eff_pos_o = (lc_eff != '0);

  // R9: a decrement at zero stays at zero
  a_r9_floor: assert property (@(posedge clk) disable iff (!rst_n)
    fin_fire_i && dec_i && !ld_req_i && lc_q == '0 |=> lc_q == '0);
  // R9: the counter only moves when an instruction finishes
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_fire_i |=> $stable(lc_q));
endmodule

// File: rtl/rpt_loop_seq.sv
module rpt_loop_seq
  import rls_pkg::*;
#(
  parameter int RCW  = 8,
  parameter int LCW  = 8,
  parameter int LITW = 6,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            head_valid_i,
  input  logic            ds_ready_i,
  input  logic            tail_full_i,
  input  logic            rep_class_i,
  input  logic            reloop_class_i,
  input  logic            pred_i,
  input  logic            dec_loop_i,
  input  logic            ld_rc_i,
  input  logic            ld_rc_inf_i,
  input  logic            ld_lc_i,
  input  logic            ld_from_data_i,
  input  logic [LITW-1:0] lit_i,
  input  logic [DW-1:0]   data_i,
  output logic            exec_o,
  output logic            requeue_o,
  output logic            retire_o,
  output logic [RCW-1:0]  rc_o,
  output logic            rc_inf_o,
  output logic [LCW-1:0]  lc_o
);
  // named internal events
  logic       step_w;
  logic       repeating_w;
  logic       finish_w;
  logic       rc_zero_w;
  logic       rc_next_zero_w;
  logic       lc_eff_pos_w;
  logic       rep_fire_w;
  logic       rc_ld_fire_w;
  logic       lc_ld_req_w;
  logic       fin_fire_w;
  step_kind_e kind_w;

  assign rep_fire_w   = step_w && repeating_w;
  assign rc_ld_fire_w = step_w && pred_i && ld_rc_i;
  assign lc_ld_req_w  = pred_i && ld_lc_i;
  assign fin_fire_w   = step_w && finish_w;

  rls_decide u_decide (
    .head_valid_i   (head_valid_i),
    .ds_ready_i     (ds_ready_i),
    .tail_full_i    (tail_full_i),
    .rep_class_i    (rep_class_i),
    .reloop_class_i (reloop_class_i),
    .pred_i         (pred_i),
    .rc_zero_i      (rc_zero_w),
    .rc_next_zero_i (rc_next_zero_w),
    .lc_eff_pos_i   (lc_eff_pos_w),
    .step_o         (step_w),
    .repeating_o    (repeating_w),
    .finish_o       (finish_w),
    .kind_o         (kind_w)
  );

  rls_rc_unit #(.RCW(RCW), .LITW(LITW), .DW(DW)) u_rc (
    .clk            (clk),
    .rst_n          (rst_n),
    .rep_fire_i     (rep_fire_w),
    .ld_fire_i      (rc_ld_fire_w),
    .ld_inf_i       (ld_rc_inf_i),
    .ld_data_i      (ld_from_data_i),
    .lit_i          (lit_i),
    .data_i         (data_i),
    .rc_o           (rc_o),
    .rc_inf_o       (rc_inf_o),
    .rc_zero_o      (rc_zero_w),
    .rc_next_zero_o (rc_next_zero_w)
  );

  rls_lc_unit #(.LCW(LCW), .LITW(LITW), .DW(DW)) u_lc (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_req_i     (lc_ld_req_w),
    .ld_data_i    (ld_from_data_i),
    .lit_i        (lit_i),
    .data_i       (data_i),
    .fin_fire_i   (fin_fire_w),
    .dec_i        (dec_loop_i),
    .lc_o         (lc_o),
    .lc_eff_pos_o (lc_eff_pos_w)
  );

  assign exec_o    = step_w && pred_i;
  assign requeue_o = (kind_w == SK_REQUEUE);
  assign retire_o  = (kind_w == SK_RETIRE);

  // R2: no head or no downstream room means silence
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(head_valid_i && ds_ready_i) |-> !exec_o && !requeue_o && !retire_o);
  // R3: a single outcome per step
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({requeue_o, retire_o}));
  // R7: requeue needs the relooping class and a positive loop test
  a_r7_reloop_terms: assert property (@(posedge clk) disable iff (!rst_n)
    requeue_o |-> reloop_class_i && lc_eff_pos_w && !rc_inf_o);
  // R11: nothing requeues into a full tail
  a_r11_tail_gate: assert property (@(posedge clk) disable iff (!rst_n)
    tail_full_i |-> !requeue_o);
  // R10: a false predicate never executes
  a_r10_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_i |-> !exec_o);
endmodule

// File: tb/rpt_loop_seq_test.sv
module rpt_loop_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic head_valid_i, ds_ready_i, tail_full_i, rep_class_i, reloop_class_i;
  logic pred_i, dec_loop_i, ld_rc_i, ld_rc_inf_i, ld_lc_i, ld_from_data_i;
  logic [5:0] lit_i;
  logic [7:0] data_i;
  logic exec_o, requeue_o, retire_o, rc_inf_o;
  logic [7:0] rc_o, lc_o;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic  ex;
    logic  rq;
    logic  rt;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  rpt_loop_seq uut (
    .clk(clk), .rst_n(rst_n), .head_valid_i(head_valid_i), .ds_ready_i(ds_ready_i),
    .tail_full_i(tail_full_i), .rep_class_i(rep_class_i), .reloop_class_i(reloop_class_i),
    .pred_i(pred_i), .dec_loop_i(dec_loop_i), .ld_rc_i(ld_rc_i), .ld_rc_inf_i(ld_rc_inf_i),
    .ld_lc_i(ld_lc_i), .ld_from_data_i(ld_from_data_i), .lit_i(lit_i), .data_i(data_i),
    .exec_o(exec_o), .requeue_o(requeue_o), .retire_o(retire_o),
    .rc_o(rc_o), .rc_inf_o(rc_inf_o), .lc_o(lc_o)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare strobes away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " exec"}, int'(exec_o), int'(e.ex));
        chk({e.tag, " requeue"}, int'(requeue_o), int'(e.rq));
        chk({e.tag, " retire"}, int'(retire_o), int'(e.rt));
      end
    end
  end

  task automatic clr();
    head_valid_i = 0; ds_ready_i = 1; tail_full_i = 0; rep_class_i = 0;
    reloop_class_i = 0; pred_i = 1; dec_loop_i = 0; ld_rc_i = 0; ld_rc_inf_i = 0;
    ld_lc_i = 0; ld_from_data_i = 0; lit_i = '0; data_i = '0;
  endtask

  task automatic instr(logic rep, logic rl, logic pr, logic dec);
    head_valid_i = 1; rep_class_i = rep; reloop_class_i = rl; pred_i = pr; dec_loop_i = dec;
  endtask

  // driver: push the expected strobes, let one edge pass, return inputs to idle
  task automatic go(logic ex, logic rq, logic rt, string tag);
    exp_t e;
    e.ex = ex; e.rq = rq; e.rt = rt; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #1;
    clr();
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr();
    #1;
    chk("R1 rc at reset", int'(rc_o), 0);
    chk("R1 inf at reset", int'(rc_inf_o), 0);
    chk("R1 lc at reset", int'(lc_o), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk("R1 strobes idle", int'(exec_o | requeue_o | retire_o), 0);

    // R2: not ready, then not valid
    instr(0, 1, 1, 0); ds_ready_i = 0; go(0, 0, 0, "R2 not ready");
    ds_ready_i = 1; go(0, 0, 0, "R2 no head");

    // R12: literal repeat load of 3
    instr(0, 1, 1, 0); ld_rc_i = 1; lit_i = 6'd3; go(1, 0, 1, "R12 rc literal load");
    chk("R12 rc literal", int'(rc_o), 3);

    // R4: three executions, then retire
    instr(1, 1, 1, 0); go(1, 0, 0, "R4 rep 1");
    chk("R4 rc after 1", int'(rc_o), 2);
    instr(1, 1, 1, 0); go(1, 0, 0, "R4 rep 2");
    instr(1, 1, 1, 0); go(1, 0, 1, "R4 rep last");
    chk("R4 rc drained", int'(rc_o), 0);

    // R8: loop load is visible to the reloop test
    instr(0, 1, 1, 0); ld_lc_i = 1; lit_i = 6'd2; go(1, 1, 0, "R8 lc load relooped");
    chk("R12 lc literal", int'(lc_o), 2);

    // R6 and R7: nonzero repeat count blocks reloop and stays put
    instr(0, 0, 1, 0); ld_rc_i = 1; lit_i = 6'd5; go(1, 0, 1, "R12 rc load 5");
    instr(0, 1, 1, 0); go(1, 0, 1, "R7 rc nonzero retires");
    chk("R6 rc untouched", int'(rc_o), 5);
    instr(0, 0, 1, 0); ld_rc_i = 1; lit_i = 6'd0; go(1, 0, 1, "R12 rc load 0");
    instr(0, 0, 1, 0); go(1, 0, 1, "R7 not reloop class");
    chk("R7 lc kept", int'(lc_o), 2);

    // R8/R9: reloop uses count before decrement, then floor at zero
    instr(0, 1, 1, 1); go(1, 1, 0, "R8 dec lc2");
    chk("R9 lc after dec", int'(lc_o), 1);
    instr(0, 1, 1, 1); go(1, 1, 0, "R8 dec lc1 still reloops");
    chk("R9 lc to zero", int'(lc_o), 0);
    instr(0, 1, 1, 1); go(1, 0, 1, "R7 lc zero retires");
    chk("R9 lc floor", int'(lc_o), 0);

    // R10: false predicate may reloop, loads ignored
    instr(0, 0, 1, 0); ld_lc_i = 1; lit_i = 6'd1; go(1, 0, 1, "R12 lc load 1");
    instr(0, 1, 0, 0); ld_rc_i = 1; lit_i = 6'd7; go(0, 1, 0, "R10 false pred reloops");
    chk("R10 rc load ignored", int'(rc_o), 0);
    instr(0, 0, 0, 0); ld_lc_i = 1; lit_i = 6'd9; go(0, 0, 1, "R10 false pred retire");
    chk("R10 lc load ignored", int'(lc_o), 1);

    // R11: tail full holds a reloop, not a retire
    instr(0, 1, 1, 0); tail_full_i = 1; go(0, 0, 0, "R11 reloop held");
    chk("R11 lc unchanged", int'(lc_o), 1);
    instr(0, 0, 1, 1); tail_full_i = 1; go(1, 0, 1, "R11 retire proceeds");
    chk("R9 dec on retire", int'(lc_o), 0);

    // R5: infinite repeat
    instr(0, 0, 1, 0); ld_rc_i = 1; ld_rc_inf_i = 1; go(1, 0, 1, "R12 inf load");
    chk("R12 inf set", int'(rc_inf_o), 1);
    for (int i = 0; i < 4; i++) begin
      instr(1, 1, 1, 0); tail_full_i = 1; go(1, 0, 0, "R5 inf repeat");
    end
    chk("R5 inf kept", int'(rc_inf_o), 1);

    // R12: loads from data
    instr(0, 0, 1, 0); ld_rc_i = 1; ld_from_data_i = 1; data_i = 8'h02; go(1, 0, 1, "R12 rc data load");
    chk("R12 rc from data", int'(rc_o), 2);
    chk("R12 inf cleared", int'(rc_inf_o), 0);
    instr(0, 0, 1, 0); ld_lc_i = 1; ld_from_data_i = 1; data_i = 8'h03; go(1, 0, 1, "R12 lc data load");
    chk("R12 lc from data", int'(lc_o), 3);

    // R10: false predicate blocks repetition
    instr(1, 0, 0, 0); go(0, 0, 1, "R10 no repeat on false pred");
    chk("R10 rc kept", int'(rc_o), 2);
    instr(1, 0, 1, 0); go(1, 0, 0, "R4 rep of 2");
    instr(1, 0, 1, 0); go(1, 0, 1, "R4 last of 2");
    // R4: count zero gives one execution, then reloop
    instr(1, 1, 1, 0); go(1, 1, 0, "R4 zero count single exec");
    chk("R4 rc stays zero", int'(rc_o), 0);

    // R12: widest literal
    instr(0, 0, 1, 0); ld_lc_i = 1; lit_i = 6'h3F; go(1, 0, 1, "R12 lc max literal");
    chk("R12 lc 63", int'(lc_o), 63);

    @(posedge clk);
    @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule